// File: doc/BRIEF.md
# Programmable-Length Up/Down Loop Counter

This block is the loop filter of a first-order all-digital phase-locked loop. It is an up/down counter that advances once per clock while enabled. A phase-detector output sets the direction. When the count runs past either end of its range, the block sends a single-cycle carry or borrow pulse to a separate increment/decrement stage. That stage then nudges the phase of the recovered clock.

A 4-bit length code sets how many counter stages are in use, and the code may change while the loop runs. A longer counter needs more consistent phase error before it emits a pulse, so the loop bandwidth narrows and lock takes longer. A short counter gives a wide, fast loop. A control path can therefore start with a short counter for quick capture and switch to a long one once lock is reached. The all-zero code parks the counter and silences both outputs.

Top module: `dpll_loop_counter`

## Requirements
- R1: When `len_code` is 0, the block emits no carry and no borrow, and it clears the count to zero. After it is re-armed with code 1 counting up, the first carry therefore comes after 8 clock edges.
- R2: A nonzero code k uses k+2 stages. The count range is 0 to 2^(k+2)-1, so under constant upward counting a carry appears every 2^(k+2) cycles.
- R3: With code 1 (three stages), carries under constant up-counting and borrows under constant down-counting repeat every 8 cycles.
- R4: With code 15 (seventeen stages), the first carry after reset comes on the 65536th enabled up-count edge, and the first borrow after reset comes on the 65537th enabled down-count edge.
- R5: `dir_up` = 1 counts up and `dir_up` = 0 counts down. A carry only follows an enabled up-count edge, and a borrow only follows an enabled down-count edge.
- R6: While `cnt_en` is 0, the count holds its value and no pulse is emitted. Counting resumes from the held value.
- R7: Counting up from the top value wraps the count to 0. Counting down from 0 wraps it to the top value of the current length. Each wrap raises `carry_o` or `borrow_o` for exactly one cycle, on the cycle after the wrapping edge. The two outputs are never high together.
- R8: After a change of `len_code`, the count is first reduced to its low k+2 bits for the new code k, and the step is applied to that value.
- R9: A synchronous active-high reset loads the midpoint 2^(k+1) of the selected range (0 for code 0) and clears both pulse outputs. With code 1 counting up, the first carry after reset therefore comes on the 4th edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset and power-on initialisation |
| cnt_en | input | 1 | Enables counting when high |
| dir_up | input | 1 | Direction from the phase detector: 1 counts up, 0 counts down |
| len_code | input | 4 | Length code: 0 disables the counter, k in 1..15 selects k+2 stages |
| carry_o | output | 1 | One-cycle pulse after an upward wrap |
| borrow_o | output | 1 | One-cycle pulse after a downward wrap |

## Verification
The bench builds the block with its default 4-bit code, which gives a 17-stage counter. This brings every length from three to seventeen stages within reach. The shortest and longest lengths get directed period checks, and a few middle lengths get reset-to-pulse and period checks. A cycle-level reference model covers random sequences in which enable, direction and length code change on every clock. That exercises masking on code changes and wrapping at every length, both within a full 17-stage half-range run.

// File: rtl/dpll_lc_pkg.sv
package dpll_lc_pkg;

    localparam int LC_CODE_W_DEF = 4;

    typedef enum logic {
        LC_DOWN = 1'b0,
        LC_UP   = 1'b1
    } lc_dir_e;

    typedef struct packed {
        logic carry;
        logic borrow;
    } lc_pulse_t;

    // Widest counter reachable with a code of the given width.
    function automatic int lc_cnt_width(input int code_w);
        return (1 << code_w) + 1;
    endfunction

    // Active stage count for a code value; zero means parked.
    function automatic int lc_stages(input int code);
        return (code == 0) ? 0 : code + 2;
    endfunction

endpackage

// File: rtl/lc_len_decode.sv
module lc_len_decode
    import dpll_lc_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 17
) (
    input  logic [CODE_W-1:0] code,
    output logic              active,
    output logic [CNT_W-1:0]  top,
    output logic [CNT_W-1:0]  mid
);
    localparam int SW = CODE_W + 2;

    logic [SW-1:0] stages;

    assign stages = SW'(lc_stages(int'(code)));
    assign active = (code != '0);

    // One mask bit per stage: set when that stage is inside the length.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign top[i] = (stages > SW'(i));
    end

    // The midpoint is the highest active stage alone.
    assign mid = top ^ (top >> 1);

endmodule

// File: rtl/lc_step_logic.sv
module lc_step_logic
    import dpll_lc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic [CNT_W-1:0] cur,
    input  logic [CNT_W-1:0] top,
    input  logic             active,
    input  logic             en,
    input  lc_dir_e          dir,
    output logic [CNT_W-1:0] nxt,
    output lc_pulse_t        pulse
);
    logic [CNT_W-1:0] fitted;

    always_comb begin
        fitted = cur & top;
        nxt    = fitted;
        pulse  = '0;
        if (active && en) begin
            if (dir == LC_UP) begin
                if (fitted == top) begin
                    nxt         = '0;
                    pulse.carry = 1'b1;
                end else begin
                    nxt = fitted + 1'b1;
                end
            end else begin
                if (fitted == '0) begin
                    nxt          = top;
                    pulse.borrow = 1'b1;
                end else begin
                    nxt = fitted - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lc_state_reg.sv
module lc_state_reg
    import dpll_lc_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] mid,
    input  logic [CNT_W-1:0] nxt,
    input  lc_pulse_t        pulse_d,
    output logic [CNT_W-1:0] cnt_q,
    output lc_pulse_t        pulse_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= mid;
            pulse_q <= '0;
        end else begin
            cnt_q   <= nxt;
            pulse_q <= pulse_d;
        end
    end

endmodule

// File: rtl/dpll_loop_counter.sv
module dpll_loop_counter
    import dpll_lc_pkg::*;
#(
    parameter  int CODE_W = LC_CODE_W_DEF,
    localparam int CNT_W  = lc_cnt_width(CODE_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              dir_up,
    input  logic [CODE_W-1:0] len_code,
    output logic              carry_o,
    output logic              borrow_o
);
    logic             active;
    logic [CNT_W-1:0] top_mask;
    logic [CNT_W-1:0] mid_val;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    lc_pulse_t        pulse_d;
    lc_pulse_t        pulse_q;

    lc_len_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
        .code   (len_code),
        .active (active),
        .top    (top_mask),
        .mid    (mid_val)
    );

    lc_step_logic #(.CNT_W(CNT_W)) u_step (
        .cur    (cnt_q),
        .top    (top_mask),
        .active (active),
        .en     (cnt_en),
        .dir    (lc_dir_e'(dir_up)),
        .nxt    (cnt_d),
        .pulse  (pulse_d)
    );

    lc_state_reg #(.CNT_W(CNT_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .mid     (mid_val),
        .nxt     (cnt_d),
        .pulse_d (pulse_d),
        .cnt_q   (cnt_q),
        .pulse_q (pulse_q)
    );

    assign carry_o  = pulse_q.carry;
    assign borrow_o = pulse_q.borrow;

endmodule

// File: rtl/lc_counter_chk.sv
module lc_counter_chk #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 17
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              dir_up,
    input logic [CODE_W-1:0] len_code,
    input logic              carry_o,
    input logic              borrow_o,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  top_mask
);
    AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (len_code == '0) |=> (!carry_o && !borrow_o)); // R1

    AST_CARRY_NEEDS_UP: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> ($past(dir_up) && $past(cnt_en))); // R5

    AST_BORROW_NEEDS_DOWN: assert property (@(posedge clk) disable iff (rst)
        borrow_o |-> (!$past(dir_up) && $past(cnt_en))); // R5

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> (!carry_o && !borrow_o)); // R6

    AST_CARRY_WRAPS_ZERO: assert property (@(posedge clk) disable iff (rst)
        carry_o |-> (cnt_q == '0)); // R7

    AST_BORROW_WRAPS_TOP: assert property (@(posedge clk) disable iff (rst)
        borrow_o |-> (cnt_q == $past(top_mask))); // R7

    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
        !(carry_o && borrow_o)); // R7

    AST_CARRY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> !carry_o); // R7

    AST_BORROW_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        borrow_o |=> !borrow_o); // R7

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        $stable(len_code) |-> ((cnt_q & ~top_mask) == '0)); // R8

endmodule

bind dpll_loop_counter lc_counter_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .dir_up   (dir_up),
    .len_code (len_code),
    .carry_o  (carry_o),
    .borrow_o (borrow_o),
    .cnt_q    (cnt_q),
    .top_mask (top_mask)
);

// File: tb/dpll_loop_counter_bench.sv
`timescale 1ns/1ps
module dpll_loop_counter_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       dir_up = 1'b1;
    logic [3:0] len_code = 4'd1;
    logic       carry_o;
    logic       borrow_o;

    int          n_checks = 0;
    int          n_errors = 0;
    int          cycles = 0;
    bit          done = 1'b0;
    string       cur_req = "R9";
    int unsigned m_cnt = 0;
    bit          exp_c = 1'b0;
    bit          exp_b = 1'b0;

    dpll_loop_counter u_dpll_loop_counter (
        .clk      (clk),
        .rst      (rst),
        .cnt_en   (cnt_en),
        .dir_up   (dir_up),
        .len_code (len_code),
        .carry_o  (carry_o),
        .borrow_o (borrow_o)
    );

    always #2 clk = ~clk;

    function automatic int unsigned span(input int code);
        return (code == 0) ? 0 : (32'd1 << (code + 2));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference: state after one clock edge with the given inputs.
    task automatic model_edge(input bit r, input bit e, input bit u, input int code);
        int unsigned s;
        int unsigned v;
        s = span(code);
        exp_c = 1'b0;
        exp_b = 1'b0;
        if (r) begin
            m_cnt = s / 2;
        end else begin
            v = (s == 0) ? 0 : m_cnt % s;
            if (e && s != 0) begin
                if (u) begin
                    if (v + 1 == s) begin v = 0; exp_c = 1'b1; end
                    else v = v + 1;
                end else begin
                    if (v == 0) begin v = s - 1; exp_b = 1'b1; end
                    else v = v - 1;
                end
            end
            m_cnt = v;
        end
    endtask

    task automatic tick(input bit e, input bit u, input int code);
        cnt_en   = e;
        dir_up   = u;
        len_code = code[3:0];
        model_edge(rst, e, u, code);
        @(posedge clk);
        @(negedge clk);
        check({cur_req, " carry"}, int'(carry_o), int'(exp_c));
        check({cur_req, " borrow"}, int'(borrow_o), int'(exp_b));
    endtask

    task automatic do_reset(input int code);
        rst = 1'b1;
        tick(1'b0, 1'b1, code);
        rst = 1'b0;
    endtask

    task automatic run_to_pulse(input bit u, input int code, input bit want_carry,
                                input int limit, output int n);
        n = 0;
        for (int k = 0; k < limit; k++) begin
            tick(1'b1, u, code);
            n++;
            if (want_carry ? carry_o : borrow_o) break;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                n_errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finish_run();
            end
        end
    end

    initial begin
        int n;
        int pulses;
        void'($urandom(32'h5eed_1c0d));
        @(negedge clk);

        // R9: reset state and midpoint start
        cur_req = "R9";
        do_reset(1);
        check("R9 carry low after reset", int'(carry_o), 0);
        check("R9 borrow low after reset", int'(borrow_o), 0);
        run_to_pulse(1'b1, 1, 1'b1, 100, n);
        check("R9 first carry from midpoint, code 1", n, 4);

        // R3: code 1 periods in both directions
        cur_req = "R3";
        run_to_pulse(1'b1, 1, 1'b1, 100, n);
        check("R3 carry period code 1", n, 8);
        run_to_pulse(1'b0, 1, 1'b0, 100, n);
        check("R3 borrow right after carry wrap", n, 1);
        run_to_pulse(1'b0, 1, 1'b0, 100, n);
        check("R3 borrow period code 1", n, 8);

        // R2: stage count follows code
        cur_req = "R2";
        for (int c = 2; c <= 6; c++) begin
            do_reset(c);
            run_to_pulse(1'b1, c, 1'b1, 1000, n);
            check("R2 first carry from midpoint", n, int'(span(c) / 2));
            run_to_pulse(1'b1, c, 1'b1, 1000, n);
            check("R2 carry period", n, int'(span(c)));
        end

        // R1: parked code is silent and clears the count
        cur_req = "R1";
        pulses = 0;
        for (int k = 0; k < 60; k++) begin
            tick($urandom_range(1, 0), $urandom_range(1, 0), 0);
            pulses += int'(carry_o) + int'(borrow_o);
        end
        check("R1 no pulses with code 0", pulses, 0);
        run_to_pulse(1'b1, 1, 1'b1, 100, n);
        check("R1 count cleared while parked", n, 8);

        // R6: enable low holds the count
        cur_req = "R6";
        do_reset(3);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b1, 3);
        pulses = 0;
        for (int k = 0; k < 20; k++) begin
            tick(1'b0, $urandom_range(1, 0), 3);
            pulses += int'(carry_o) + int'(borrow_o);
        end
        check("R6 no pulses while disabled", pulses, 0);
        run_to_pulse(1'b1, 3, 1'b1, 100, n);
        check("R6 resumes from held value", n, 11);

        // R5: down counting never carries
        cur_req = "R5";
        pulses = 0;
        n = 0;
        for (int k = 0; k < 40; k++) begin
            tick(1'b1, 1'b0, 1);
            pulses += int'(carry_o);
            n += int'(borrow_o);
        end
        check("R5 no carry while counting down", pulses, 0);
        check("R5 borrows while counting down", n, 5);

        // R8: code change masks the count (52 & 7 = 4)
        cur_req = "R8";
        do_reset(4);
        for (int k = 0; k < 20; k++) tick(1'b1, 1'b1, 4);
        run_to_pulse(1'b1, 1, 1'b1, 100, n);
        check("R8 masked count after shortening", n, 4);

        // R7: random traffic against the reference
        cur_req = "R7";
        do_reset(2);
        for (int k = 0; k < 4000; k++) begin
            tick(($urandom_range(9, 0) != 0), $urandom_range(1, 0),
                 ($urandom_range(7, 0) == 0) ? int'($urandom_range(15, 0))
                                             : int'(len_code));
            check("R7 never both pulses", int'(carry_o && borrow_o), 0);
        end

        // R4: seventeen stages
        cur_req = "R4";
        do_reset(15);
        run_to_pulse(1'b1, 15, 1'b1, 70000, n);
        check("R4 first carry code 15", n, 65536);
        do_reset(15);
        run_to_pulse(1'b0, 15, 1'b0, 70000, n);
        check("R4 first borrow code 15", n, 65537);

        finish_run();
    end

endmodule